// File: doc/BRIEF.md
# Line Driver Mode Latch Decoder

This block models, at the logic level, the mode-control input of a subscriber line driver. A three-level load strobe, given here as a 2-bit level code, qualifies a 3-bit parallel control bus. When the strobe is at its high level, the bus is captured into a 3-bit mode register. At the mid level the register is frozen. At the low level the bus must rest at all zeros. A bus that is nonzero at the low level, or a strobe that carries the unused fourth code, is reported as a protocol error and never changes the register.

The mode register drives a registered decoder. The decoder turns the 3-bit code into these line-driver controls: battery selection, tip and ring amplifier enables, tip and ring high-impedance, ring clamp, fixed longitudinal voltage, internal ringing, and a flag for the reserved code. The reserved code decodes to the same safe, fully disconnected outputs as Disconnect. All controls are plain level pins. There is no streaming data path, so the block has no handshake.

Top module: `line_mode_latch`

## Requirements
- R1: With `load_lvl` = 2'b10 (high) at a rising clock edge, `mode_code` takes the value of `ctrl_bus` at that edge, with bit 0 = C1, bit 1 = C2 and bit 2 = C3.
- R2: With `load_lvl` = 2'b01 (mid) at an edge, `mode_code` keeps its value whatever `ctrl_bus` carries.
- R3: With `load_lvl` = 2'b00 (low) at an edge, `mode_code` keeps its value. `bus_err` is 1 after that edge exactly when `ctrl_bus` was nonzero, and 0 when it was zero.
- R4: With `load_lvl` = 2'b11 at an edge, `mode_code` keeps its value and `bus_err` is 1 after that edge. With 2'b01 or 2'b10, `bus_err` is 0 after the edge.
- R5: While `rst_n` is low, `mode_code` is 000, `bus_err` is 0 and the decoded outputs show the Standby combination.
- R6: The decoded outputs follow `mode_code` one clock later: after edge N they show the decode of the `mode_code` held after edge N-1.
- R7: Code 000 (Standby): high battery, both amplifiers off, neither output high-impedance, ring clamp on, all other enables off.
- R8: Code 001 (Tip Open): high battery, both amplifiers off, tip high-impedance, ring not high-impedance, ring clamp on.
- R9: Code 010 (on-hook transmission): high battery, both amplifiers on, fixed longitudinal voltage on, clamp and ringing off.
- R10: Code 011 (Disconnect): low battery, both amplifiers off, both outputs high-impedance, clamp off.
- R11: Code 100 (reserved): same outputs as Disconnect, with `rsvd_code` = 1. `rsvd_code` is 0 for every other code.
- R12: Codes 101, 110 and 111: both amplifiers on, no high-impedance, no clamp. Battery is high, low and high in that order, and `ring_en` is 1 only for 111.
- R13: `ring_clamp_en` is 1 only for codes 000 and 001. Whenever it is 1, both amplifiers are off.
- R14: `bat_high_sel` is 0 only for codes 011, 100 and 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_lvl | input | 2 | Strobe level: 00 low, 01 mid, 10 high, 11 illegal |
| ctrl_bus | input | 3 | Control bus, bit 0 = C1, bit 2 = C3 |
| mode_code | output | 3 | Latched mode register |
| bus_err | output | 1 | Protocol violation seen at the previous edge |
| bat_high_sel | output | 1 | 1 selects high battery, 0 low battery |
| tip_amp_en | output | 1 | Tip amplifier enable |
| tip_hiz | output | 1 | Tip output high-impedance |
| ring_amp_en | output | 1 | Ring amplifier enable |
| ring_hiz | output | 1 | Ring output high-impedance |
| ring_clamp_en | output | 1 | Ring clamp enable |
| flv_en | output | 1 | Fixed longitudinal voltage enable |
| ring_en | output | 1 | Internal ringing enable |
| rsvd_code | output | 1 | Reserved code is latched |

## Verification
The hardest case to reach is a violation that arrives while a non-default mode is latched. A violation that arrives in Standby tells nothing, because a wrongly loaded zero looks the same as no load. The stimulus therefore first loads each of the eight codes at the high level. It then drives nonzero bus patterns at the low level, and every bus pattern at the mid level and at the illegal strobe code. Each expectation is queued one edge ahead, so the one-cycle lag of the decoded outputs is checked on every transition.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } load_lvl_e;

  typedef enum logic [CODE_W-1:0] {
    M_STANDBY  = 3'b000,
    M_TIP_OPEN = 3'b001,
    M_OHT_FLV  = 3'b010,
    M_DISCONN  = 3'b011,
    M_RESERVED = 3'b100,
    M_ACT_HIGH = 3'b101,
    M_ACT_LOW  = 3'b110,
    M_RINGING  = 3'b111
  } mode_e;

  typedef struct packed {
    logic bat_high;
    logic tip_amp;
    logic tip_hiz;
    logic ring_amp;
    logic ring_hiz;
    logic clamp;
    logic flv;
    logic ringing;
    logic rsvd;
  } line_ctl_t;

  function automatic line_ctl_t decode_mode(input logic [CODE_W-1:0] code);
    line_ctl_t c;
    c = '0;
    unique case (code)
      M_STANDBY: begin
        c.bat_high = 1'b1;
        c.clamp    = 1'b1;
      end
      M_TIP_OPEN: begin
        c.bat_high = 1'b1;
        c.tip_hiz  = 1'b1;
        c.clamp    = 1'b1;
      end
      M_OHT_FLV: begin
        c.bat_high = 1'b1;
        c.tip_amp  = 1'b1;
        c.ring_amp = 1'b1;
        c.flv      = 1'b1;
      end
      M_DISCONN: begin
        c.tip_hiz  = 1'b1;
        c.ring_hiz = 1'b1;
      end
      M_RESERVED: begin
        c.tip_hiz  = 1'b1;
        c.ring_hiz = 1'b1;
        c.rsvd     = 1'b1;
      end
      M_ACT_HIGH: begin
        c.bat_high = 1'b1;
        c.tip_amp  = 1'b1;
        c.ring_amp = 1'b1;
      end
      M_ACT_LOW: begin
        c.tip_amp  = 1'b1;
        c.ring_amp = 1'b1;
      end
      default: begin
        c.bat_high = 1'b1;
        c.tip_amp  = 1'b1;
        c.ring_amp = 1'b1;
        c.ringing  = 1'b1;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lmd_strobe_qual.sv
module lmd_strobe_qual
  import lmd_pkg::*;
#(
  parameter int BUS_W = CODE_W
) (
  input  logic [1:0]       lvl,
  input  logic [BUS_W-1:0] bus,
  output logic             load_en,
  output logic             viol
);
  always_comb begin
    load_en = 1'b0;
    viol    = 1'b0;
    unique case (load_lvl_e'(lvl))
      LVL_HIGH: load_en = 1'b1;
      LVL_MID:  ;
      LVL_LOW:  viol = |bus;
      default:  viol = 1'b1;
    endcase
  end
endmodule

// File: rtl/lmd_mode_reg.sv
module lmd_mode_reg
  import lmd_pkg::*;
#(
  parameter int                BUS_W     = CODE_W,
  parameter logic [BUS_W-1:0]  RST_CODE  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lvl,
  input  logic             load_en,
  input  logic             viol,
  input  logic [BUS_W-1:0] bus,
  output logic [BUS_W-1:0] code_q,
  output logic             err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      err_q  <= 1'b0;
    end else begin
      if (load_en) code_q <= bus;
      err_q <= viol;
    end
  end

  a_r1_load_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_HIGH) |=> (code_q == $past(bus)));
  a_r2_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_MID) |=> ($stable(code_q) && !err_q));
  a_r3_low_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_LOW && bus != '0) |=> (err_q && $stable(code_q)));
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_LOW && bus == '0) |=> (!err_q && $stable(code_q)));
  a_r4_bad_level: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_BAD) |=> (err_q && $stable(code_q)));
endmodule

// File: rtl/lmd_decode_reg.sv
module lmd_decode_reg
  import lmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output line_ctl_t         ctl_q
);
  localparam line_ctl_t RST_CTL = decode_mode(M_STANDBY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= RST_CTL;
    else        ctl_q <= decode_mode(code);
  end

  a_r13_clamp_amps_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.clamp |-> (!ctl_q.tip_amp && !ctl_q.ring_amp));
  a_r13_clamp_codes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ctl_q.clamp == ($past(code) == M_STANDBY || $past(code) == M_TIP_OPEN)));
  a_r11_rsvd_safe: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.rsvd |-> (!ctl_q.tip_amp && !ctl_q.ring_amp && ctl_q.tip_hiz
                    && ctl_q.ring_hiz && !ctl_q.bat_high));
  a_r6_hiz_amp_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.tip_hiz || ctl_q.ring_hiz) |-> (!ctl_q.tip_amp && !ctl_q.ring_amp));
  a_r12_ringing_high_bat: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.ringing |-> (ctl_q.bat_high && ctl_q.tip_amp && ctl_q.ring_amp));
endmodule

// File: rtl/line_mode_latch.sv
module line_mode_latch
  import lmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] load_lvl,
  input  logic [2:0] ctrl_bus,
  output logic [2:0] mode_code,
  output logic       bus_err,
  output logic       bat_high_sel,
  output logic       tip_amp_en,
  output logic       tip_hiz,
  output logic       ring_amp_en,
  output logic       ring_hiz,
  output logic       ring_clamp_en,
  output logic       flv_en,
  output logic       ring_en,
  output logic       rsvd_code
);
  logic      load_en;
  logic      viol;
  line_ctl_t ctl;

  lmd_strobe_qual #(.BUS_W(CODE_W)) u_qual (
    .lvl     (load_lvl),
    .bus     (ctrl_bus),
    .load_en (load_en),
    .viol    (viol)
  );

  lmd_mode_reg #(.BUS_W(CODE_W), .RST_CODE(M_STANDBY)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (load_lvl),
    .load_en (load_en),
    .viol    (viol),
    .bus     (ctrl_bus),
    .code_q  (mode_code),
    .err_q   (bus_err)
  );

  lmd_decode_reg u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (mode_code),
    .ctl_q (ctl)
  );

  assign bat_high_sel  = ctl.bat_high;
  assign tip_amp_en    = ctl.tip_amp;
  assign tip_hiz       = ctl.tip_hiz;
  assign ring_amp_en   = ctl.ring_amp;
  assign ring_hiz      = ctl.ring_hiz;
  assign ring_clamp_en = ctl.clamp;
  assign flv_en        = ctl.flv;
  assign ring_en       = ctl.ringing;
  assign rsvd_code     = ctl.rsvd;

  a_r14_low_bat_codes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bat_high_sel != ($past(mode_code) == M_DISCONN
                               || $past(mode_code) == M_RESERVED
                               || $past(mode_code) == M_ACT_LOW)));
endmodule

// File: tb/line_mode_latch_tb.sv
module line_mode_latch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] load_lvl = 2'b01;
  logic [2:0] ctrl_bus = 3'b000;
  logic [2:0] mode_code;
  logic       bus_err;
  logic       bat_high_sel, tip_amp_en, tip_hiz, ring_amp_en, ring_hiz;
  logic       ring_clamp_en, flv_en, ring_en, rsvd_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [2:0] mode;
    logic       err;
    logic [8:0] dec;
    logic [2:0] dec_code;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [2:0] model_mode = 3'b000;

  line_mode_latch u_dut (
    .clk(clk), .rst_n(rst_n), .load_lvl(load_lvl), .ctrl_bus(ctrl_bus),
    .mode_code(mode_code), .bus_err(bus_err), .bat_high_sel(bat_high_sel),
    .tip_amp_en(tip_amp_en), .tip_hiz(tip_hiz), .ring_amp_en(ring_amp_en),
    .ring_hiz(ring_hiz), .ring_clamp_en(ring_clamp_en), .flv_en(flv_en),
    .ring_en(ring_en), .rsvd_code(rsvd_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // order: bat_high, tip_amp, tip_hiz, ring_amp, ring_hiz, clamp, flv, ringing, rsvd
  function automatic logic [8:0] expect_dec(input logic [2:0] c);
    case (c)
      3'b000: return 9'b1_0_0_0_0_1_0_0_0; // R7
      3'b001: return 9'b1_0_1_0_0_1_0_0_0; // R8
      3'b010: return 9'b1_1_0_1_0_0_1_0_0; // R9
      3'b011: return 9'b0_0_1_0_1_0_0_0_0; // R10
      3'b100: return 9'b0_0_1_0_1_0_0_0_1; // R11
      3'b101: return 9'b1_1_0_1_0_0_0_0_0; // R12
      3'b110: return 9'b0_1_0_1_0_0_0_0_0; // R12
      default: return 9'b1_1_0_1_0_0_0_1_0; // R12
    endcase
  endfunction

  function automatic string code_tag(input logic [2:0] c);
    case (c)
      3'b000: return "R7";
      3'b001: return "R8";
      3'b010: return "R9";
      3'b011: return "R10";
      3'b100: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [8:0] dut_dec();
    return {bat_high_sel, tip_amp_en, tip_hiz, ring_amp_en, ring_hiz,
            ring_clamp_en, flv_en, ring_en, rsvd_code};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed to scoreboard
  task automatic drive(input logic [1:0] lvl, input logic [2:0] bus, input string tag);
    exp_t e;
    @(negedge clk);
    load_lvl = lvl;
    ctrl_bus = bus;
    e.dec      = expect_dec(model_mode);
    e.dec_code = model_mode;
    if (lvl == 2'b10) model_mode = bus;
    e.mode = model_mode;
    e.err  = (lvl == 2'b11) || (lvl == 2'b00 && bus != 3'b000);
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " mode_code"}, {6'b0, mode_code}, {6'b0, e.mode});
        check({e.tag, " bus_err"}, {8'b0, bus_err}, {8'b0, e.err});
        check({"R6 ", code_tag(e.dec_code), " decode"}, dut_dec(), e.dec);
        check("R13 clamp", {8'b0, ring_clamp_en},
              {8'b0, (e.dec_code == 3'b000 || e.dec_code == 3'b001)});
        check("R14 battery", {8'b0, bat_high_sel},
              {8'b0, !(e.dec_code == 3'b011 || e.dec_code == 3'b100 || e.dec_code == 3'b110)});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R5: reset state
    check("R5 mode_code", {6'b0, mode_code}, 9'd0);
    check("R5 bus_err", {8'b0, bus_err}, 9'd0);
    check("R5 decode", dut_dec(), expect_dec(3'b000));
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < 8; c++) begin
      drive(2'b10, 3'(c), "R1");
      drive(2'b01, 3'(c), "R2");
      for (int b = 1; b < 8; b++) drive(2'b00, 3'(b), "R3");
      drive(2'b00, 3'b000, "R3");
      drive(2'b11, 3'(7 - c), "R4");
      for (int b = 0; b < 8; b++) drive(2'b01, 3'(b), "R2");
      drive(2'b01, 3'(c), "R2");
    end
    for (int c = 7; c >= 0; c--) begin
      drive(2'b10, 3'(c), "R1");
      drive(2'b10, 3'(c ^ 3), "R1");
      drive(2'b11, 3'b000, "R4");
    end
    drive(2'b01, 3'b000, "R2");
    drive(2'b01, 3'b000, "R2");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule